// File: doc/BRIEF.md
# Display Frame Sync Status Controller

This block follows the vertical timing of an LCD refresh by counting line strobes against four programmable counts: active lines, front porch, sync width and back porch. From the line position it raises sticky status flags that tell software when it may safely change display settings or frame-buffer memory. Another flag records the fetch-complete pulse from an external DMA engine.

Software writes display settings into a shadow register at any time. The shadow copy moves into the active copy at one fixed point in each frame: the strobe that starts the last blanking line, one line before the next refresh begins. That transfer sets a lock flag. After it, the active copy stays unchanged until the next lock point, and any later writes wait in the shadow. An early-warning flag fires a programmable number of lines before blanking starts. Each flag has an enable bit, and the enabled flags are ORed into a single interrupt line.

Top module: `frame_sync_ctrl`

## Requirements
- R1: A line counter starts at line 0 after reset and advances by one only on a cycle with `line_strobe` high. Lines 0 to A-1 are active and the F+S+B lines after them are blanking. After line A+F+S+B-1 the counter returns to 0.
- R2: Status bit 0 (blank start) is set by the strobe that moves the counter into line A.
- R3: Status bit 1 (pre-blank warning) is set by the strobe that moves the counter into line A-W, where W is `warn_lines`.
- R4: The strobe that moves the counter into line A+F+S+B-1 copies the shadow register into `active_cfg`. A `cfg_wr` in that same cycle goes only to the shadow and takes effect at the following lock.
- R5: Status bit 2 (config locked) is set by that same strobe. `active_cfg` never changes in any other cycle, so writes made after the lock cannot reach it before the next lock.
- R6: Status bit 3 (fetch done) is set by a cycle with `fetch_done` high, whatever the line position.
- R7: Status bit 4 (frame start) is set by the strobe that wraps the counter to line 0.
- R8: If W is 0, bit 1 is set in the same cycle as bit 0. If W is A or more, bit 1 is set in the same cycle as bit 4, at line 0.
- R9: `irq` is high exactly when some status bit and its `irq_mask` bit are both 1. It follows `status` with no added delay.
- R10: Status bits stay set until cleared. A `clr_wr` cycle clears each bit that is 1 in `clr_bits`. A set and a clear of the same bit in one cycle leave the bit set.
- R11: While reset is held, and after it releases, `status`, `active_cfg` and the shadow read 0. A flag event shows on `status` one clock after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_strobe | input | 1 | One-cycle pulse per display line |
| fetch_done | input | 1 | One-cycle pulse from the DMA engine when the frame has been read |
| act_lines | input | LINE_W | Active line count A (at least 1) |
| fp_lines | input | LINE_W | Front porch lines F (at least 1) |
| sync_lines | input | LINE_W | Sync width lines S (at least 1) |
| bp_lines | input | LINE_W | Back porch lines B (at least 1) |
| warn_lines | input | LINE_W | Pre-blank warning distance W in lines |
| cfg_wr | input | 1 | Write strobe for the shadow configuration |
| cfg_wdata | input | CFG_W | Shadow configuration write data |
| clr_wr | input | 1 | Status clear strobe |
| clr_bits | input | 5 | Status bits to clear (1 clears) |
| irq_mask | input | 5 | Per-flag interrupt enables |
| status | output | 5 | Sticky flags: bit0 blank start, bit1 pre-blank, bit2 locked, bit3 fetch done, bit4 frame start |
| active_cfg | output | CFG_W | Configuration in use for the current refresh |
| irq | output | 1 | Interrupt request |

## Verification
The core function runs under random strobe spacing, random fetch pulses, random shadow writes and random clears, with three timing sets. A normal warning distance keeps the warning line apart from the other event lines. A zero distance must put the warning on the blank-start line. A distance beyond the active count must put it on the frame-start line. Any error in the decode of these edge cases shows up as a flag in the wrong cycle. Writes that land on the lock cycle or after it show whether the active copy takes the value from before the lock or is disturbed afterwards. Clears that coincide with new events confirm that a set wins over a clear.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int unsigned NFLAG = 5;
  localparam int unsigned F_BLANK  = 0;
  localparam int unsigned F_WARN   = 1;
  localparam int unsigned F_LOCK   = 2;
  localparam int unsigned F_FETCH  = 3;
  localparam int unsigned F_FRAME  = 4;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/fsc_line_timer.sv
module fsc_line_timer #(
  parameter int unsigned LINE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic [LINE_W-1:0]   act_lines,
  input  logic [LINE_W-1:0]   fp_lines,
  input  logic [LINE_W-1:0]   sync_lines,
  input  logic [LINE_W-1:0]   bp_lines,
  input  logic [LINE_W-1:0]   warn_lines,
  output logic [LINE_W+1:0]   line_q,
  output logic [LINE_W+1:0]   total_lines,
  output logic                ev_blank,
  output logic                ev_warn,
  output logic                ev_lock,
  output logic                ev_frame
);
  localparam int unsigned TW = LINE_W + 2;

  logic [TW-1:0] last_line;
  logic [TW-1:0] step_line;
  logic [TW-1:0] warn_line;
  logic [TW-1:0] act_ext;
  logic [TW-1:0] line_d;

  always_comb begin
    act_ext     = TW'(act_lines);
    total_lines = act_ext + TW'(fp_lines) + TW'(sync_lines) + TW'(bp_lines);
    last_line   = total_lines - TW'(1);
    step_line   = (line_q == last_line) ? '0 : line_q + TW'(1);
    if (TW'(warn_lines) >= act_ext) warn_line = '0;
    else                            warn_line = act_ext - TW'(warn_lines);
    ev_blank = strobe && (step_line == act_ext);
    ev_warn  = strobe && (step_line == warn_line);
    ev_lock  = strobe && (step_line == last_line);
    ev_frame = strobe && (step_line == '0);
    line_d   = strobe ? step_line : line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end
endmodule

// File: rtl/fsc_cfg_shadow.sv
module fsc_cfg_shadow #(
  parameter int unsigned CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             lock,
  output logic [CFG_W-1:0] shadow_q,
  output logic [CFG_W-1:0] active_q
);
  logic [CFG_W-1:0] shadow_d;
  logic [CFG_W-1:0] active_d;

  always_comb begin
    shadow_d = wr_en ? wr_data : shadow_q;
    active_d = lock ? shadow_q : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end
endmodule

// File: rtl/fsc_irq_status.sv
module fsc_irq_status
  import fsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_vec,
  input  logic      clr_wr,
  input  flag_vec_t clr_bits,
  input  flag_vec_t mask,
  output flag_vec_t status_q,
  output logic      irq
);
  flag_vec_t status_d;
  flag_vec_t clr_vec;

  always_comb begin
    clr_vec  = clr_wr ? clr_bits : '0;
    status_d = (status_q & ~clr_vec) | set_vec;
    irq      = |(status_q & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/frame_sync_ctrl.sv
module frame_sync_ctrl
  import fsc_pkg::*;
#(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_strobe,
  input  logic              fetch_done,
  input  logic [LINE_W-1:0] act_lines,
  input  logic [LINE_W-1:0] fp_lines,
  input  logic [LINE_W-1:0] sync_lines,
  input  logic [LINE_W-1:0] bp_lines,
  input  logic [LINE_W-1:0] warn_lines,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              clr_wr,
  input  logic [4:0]        clr_bits,
  input  logic [4:0]        irq_mask,
  output logic [4:0]        status,
  output logic [CFG_W-1:0]  active_cfg,
  output logic              irq
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [LINE_W+1:0]      line_q;
  logic [LINE_W+1:0]      total_lines;
  logic                   ev_blank, ev_warn, ev_lock, ev_frame;
  logic [CFG_W-1:0]       shadow_q;
  flag_vec_t              set_vec;
  flag_vec_t              status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  fsc_line_timer #(.LINE_W(LINE_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .strobe     (line_strobe),
    .act_lines  (act_lines),
    .fp_lines   (fp_lines),
    .sync_lines (sync_lines),
    .bp_lines   (bp_lines),
    .warn_lines (warn_lines),
    .line_q     (line_q),
    .total_lines(total_lines),
    .ev_blank   (ev_blank),
    .ev_warn    (ev_warn),
    .ev_lock    (ev_lock),
    .ev_frame   (ev_frame)
  );

  fsc_cfg_shadow #(.CFG_W(CFG_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_wr),
    .wr_data (cfg_wdata),
    .lock    (ev_lock),
    .shadow_q(shadow_q),
    .active_q(active_cfg)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[F_BLANK] = ev_blank;
    set_vec[F_WARN]  = ev_warn;
    set_vec[F_LOCK]  = ev_lock;
    set_vec[F_FETCH] = fetch_done;
    set_vec[F_FRAME] = ev_frame;
  end

  fsc_irq_status u_stat (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (set_vec),
    .clr_wr  (clr_wr),
    .clr_bits(clr_bits),
    .mask    (irq_mask),
    .status_q(status_q),
    .irq     (irq)
  );

  assign status = status_q;
endmodule

// File: rtl/frame_sync_ctrl_chk.sv
module frame_sync_ctrl_chk #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned CFG_W  = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              line_strobe,
  input logic              fetch_done,
  input logic              clr_wr,
  input logic [4:0]        irq_mask,
  input logic [4:0]        status,
  input logic              irq,
  input logic [CFG_W-1:0]  active_cfg,
  input logic              ev_lock,
  input logic [LINE_W+1:0] line_q,
  input logic [LINE_W+1:0] total_lines
);
  AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    line_q < total_lines) else $error("line counter out of frame"); // R1
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !line_strobe |=> $stable(line_q)) else $error("line moved without strobe"); // R1
  AST_ACTIVE_ONLY_AT_LOCK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ev_lock |=> $stable(active_cfg)) else $error("active copy changed outside lock"); // R5
  AST_LOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_lock |=> status[2]) else $error("lock flag missing"); // R5
  AST_FETCH_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fetch_done |=> status[3]) else $error("fetch flag missing"); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clr_wr |=> ((status & $past(status)) == $past(status))) else $error("flag dropped"); // R10
  AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_mask == 5'd0) |-> !irq) else $error("irq with all masked"); // R9
endmodule

bind frame_sync_ctrl frame_sync_ctrl_chk #(.LINE_W(LINE_W), .CFG_W(CFG_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .line_strobe(line_strobe),
  .fetch_done (fetch_done),
  .clr_wr     (clr_wr),
  .irq_mask   (irq_mask),
  .status     (status),
  .irq        (irq),
  .active_cfg (active_cfg),
  .ev_lock    (ev_lock),
  .line_q     (line_q),
  .total_lines(total_lines)
);

// File: tb/test_frame_sync_ctrl.sv
`timescale 1ns/1ps
module test_frame_sync_ctrl;
  localparam int unsigned LINE_W = 10;
  localparam int unsigned CFG_W  = 16;

  logic              clk;
  logic              rst_n;
  logic              line_strobe, fetch_done, cfg_wr, clr_wr;
  logic [LINE_W-1:0] act_lines, fp_lines, sync_lines, bp_lines, warn_lines;
  logic [CFG_W-1:0]  cfg_wdata;
  logic [4:0]        clr_bits, irq_mask, status;
  logic [CFG_W-1:0]  active_cfg;
  logic              irq;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          done     = 0;

  int unsigned m_line;
  logic [4:0]  m_stat;
  logic [CFG_W-1:0] m_sh, m_act;
  int unsigned n_coinc_blank = 0;
  int unsigned n_coinc_frame = 0;

  frame_sync_ctrl #(.LINE_W(LINE_W), .CFG_W(CFG_W)) i_frame_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .fetch_done(fetch_done),
    .act_lines(act_lines), .fp_lines(fp_lines), .sync_lines(sync_lines),
    .bp_lines(bp_lines), .warn_lines(warn_lines), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .clr_wr(clr_wr), .clr_bits(clr_bits),
    .irq_mask(irq_mask), .status(status), .active_cfg(active_cfg), .irq(irq)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int unsigned warn_target(int unsigned a, int unsigned w);
    return (w >= a) ? 0 : a - w;
  endfunction

  // Bench model of one clock edge, from the requirements.
  task automatic model_edge();
    int unsigned tot, nl;
    logic [4:0] setv;
    setv = '0;
    tot  = act_lines + fp_lines + sync_lines + bp_lines;
    if (line_strobe) begin
      nl = (m_line == tot - 1) ? 0 : m_line + 1;          // R1
      if (nl == act_lines) setv[0] = 1;                     // R2
      if (nl == warn_target(act_lines, warn_lines)) setv[1] = 1; // R3 R8
      if (nl == tot - 1) begin setv[2] = 1; m_act = m_sh; end    // R4 R5
      if (nl == 0) setv[4] = 1;                             // R7
      m_line = nl;
    end
    if (fetch_done) setv[3] = 1;                            // R6
    if (setv[1] && setv[0]) n_coinc_blank++;
    if (setv[1] && setv[4]) n_coinc_frame++;
    m_stat = (m_stat & ~(clr_wr ? clr_bits : 5'd0)) | setv; // R10
    if (cfg_wr) m_sh = cfg_wdata;
  endtask

  task automatic compare();
    check(status[0] == m_stat[0], "R2 blank flag", status[0], m_stat[0]);
    check(status[1] == m_stat[1], "R3 warn flag", status[1], m_stat[1]);
    check(status[2] == m_stat[2], "R5 lock flag", status[2], m_stat[2]);
    check(status[3] == m_stat[3], "R6 fetch flag", status[3], m_stat[3]);
    check(status[4] == m_stat[4], "R7 frame flag", status[4], m_stat[4]);
    check(active_cfg == m_act, "R4 active cfg", active_cfg, m_act);
    check(irq == |(m_stat & irq_mask), "R9 irq", irq, |(m_stat & irq_mask));
  endtask

  task automatic idle_inputs();
    line_strobe = 0; fetch_done = 0; cfg_wr = 0; clr_wr = 0;
    clr_bits = '0; cfg_wdata = '0;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(input int a, input int f, input int s, input int b, input int w);
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    act_lines = LINE_W'(a); fp_lines = LINE_W'(f); sync_lines = LINE_W'(s);
    bp_lines = LINE_W'(b); warn_lines = LINE_W'(w);
    m_line = 0; m_stat = '0; m_sh = '0; m_act = '0;
    repeat (3) @(negedge clk);
    check(status == 5'd0, "R11 reset status", status, 0);
    check(active_cfg == '0, "R11 reset active", active_cfg, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(status == 5'd0 && irq == 0, "R11 post-release idle", status, 0);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      line_strobe = ($urandom % 3) == 0;
      fetch_done  = ($urandom % 16) == 0;
      cfg_wr      = ($urandom % 4) == 0;
      cfg_wdata   = CFG_W'($urandom);
      clr_wr      = ($urandom % 6) == 0;
      clr_bits    = 5'($urandom);
      if (i % 97 == 0) irq_mask = 5'($urandom);
      cycle();
    end
    idle_inputs();
  endtask

  initial begin
    process::self().srandom(32'd1357);
    rst_n = 0; irq_mask = 5'h1f;
    idle_inputs();
    act_lines = 6; fp_lines = 2; sync_lines = 1; bp_lines = 2; warn_lines = 2;

    // Normal warning distance
    do_reset(6, 2, 1, 2, 2);
    // Directed: shadow write then strobes up to the lock line (line 10)
    cfg_wr = 1; cfg_wdata = 16'hA5C3; cycle(); cfg_wr = 0;
    for (int k = 0; k < 10; k++) begin line_strobe = 1; cycle(); line_strobe = 0; cycle(); end
    check(active_cfg == 16'hA5C3, "R4 lock takes shadow", active_cfg, 16'hA5C3);
    check(status[2] == 1'b1, "R5 lock flag directed", status[2], 1);
    // Write after lock must not reach the active copy
    cfg_wr = 1; cfg_wdata = 16'h0F0F; cycle(); cfg_wr = 0;
    check(active_cfg == 16'hA5C3, "R5 write after lock ignored", active_cfg, 16'hA5C3);
    // Clear and set in same cycle: set wins (wrap to line 0 sets bit 4)
    clr_wr = 1; clr_bits = 5'h1f; line_strobe = 1; cycle(); idle_inputs(); cycle();
    check(status == 5'b10000, "R10 set beats clear", status, 5'b10000);
    irq_mask = 5'b01111; cycle();
    check(irq == 0, "R9 masked flag", irq, 0);
    random_run(1500);

    // Zero warning distance
    do_reset(5, 1, 2, 1, 0);
    random_run(1500);
    check(n_coinc_blank > 0, "R8 warn with blank seen", n_coinc_blank, 1);

    // Warning distance beyond active lines
    do_reset(4, 2, 1, 3, 9);
    random_run(1500);
    check(n_coinc_frame > 0, "R8 warn with frame seen", n_coinc_frame, 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule